// File: doc/BRIEF.md
# Console Terminal and Interrupt I/O Unit

This unit carries out the device-transfer instructions of a 12-bit accumulator machine for three devices: an interrupt controller, a keyboard receiver and a printer transmitter. For each instruction word the CPU presents it with `instr_valid`, together with the current accumulator. One clock later the unit returns four things: a skip request, an optional accumulator write, an optional transmit request with its character, and an illegal-instruction pulse. The unit also keeps an interrupt-pending level up to date at all times.

Inside, the unit holds the interrupt enable and the delayed enable, the two keyboard interrupt-enable bits, the receive and transmit flags, the received character and the character being sent. A receive strobe from the serial side stores a character. A transmit-done pulse reports that the printer is ready again. Instructions from other groups still count as completed instructions for the delayed enable, but they cause no I/O action.

Top module: `conio_unit`

## Requirements
- R1: An instruction is an I/O transfer only when bits 11..9 equal 6. Bits 8..3 then give the device: 0 is the interrupt controller, 3 the keyboard, 4 the printer. Bits 2..0 give the sub-operation. A valid word from another group produces no skip, no accumulator write, no transmit request and no illegal pulse.
- R2: On the interrupt controller, sub-op 1 sets the delayed enable and sub-op 2 clears both the enable and the delayed enable. Sub-op 0 requests a skip when the active enable is set.
- R3: The delayed enable becomes the active enable only when the next legal instruction after the enabling one completes. Idle cycles and illegal words do not move it. The completing instruction itself still sees the old active enable.
- R4: `irq_pending` is (keyboard-enable bit 0 AND receive flag) OR (keyboard-enable bit 1 AND transmit flag). Controller sub-op 3 requests a skip when it is set.
- R5: `rx_strobe` stores the 8-bit `rx_char` and sets the receive flag. Keyboard sub-op 1 requests a skip when the receive flag is set.
- R6: Keyboard sub-op 6 asserts `acc_we` with the stored character zero-extended to 12 bits and clears the receive flag.
- R7: Keyboard sub-op 5 loads the keyboard interrupt-enable bits from accumulator bits 1..0.
- R8: Printer sub-op 0 sets the transmit flag and sub-op 2 clears it. Sub-op 1 requests a skip when the flag is set. A `tx_done` pulse sets the flag.
- R9: Printer sub-op 4 pulses `tx_req` for one cycle and loads `tx_char` from accumulator bits 7..0, leaving the transmit flag unchanged. Sub-op 6 does the same and also clears the flag.
- R10: Printer sub-op 5 requests a skip when either the receive flag or the transmit flag is set.
- R11: Any other device or sub-operation in the I/O group pulses `illegal` for one cycle and changes no state.
- R12: `skip`, `acc_we`, `acc_wdata`, `tx_req` and `illegal` are registered: they answer the word of the previous cycle and are zero when that cycle had no valid word. A `rx_strobe` or `tx_done` in the same cycle as an instruction that clears the matching flag wins, and the flag ends up set.
- R13: Reset clears every flag, enable, character register and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction word is presented this cycle |
| instr | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator value |
| rx_strobe | input | 1 | A received character is available |
| rx_char | input | 8 | Received character |
| tx_done | input | 1 | Printer finished the last character |
| skip | output | 1 | Skip the next instruction |
| acc_we | output | 1 | Write `acc_wdata` into the accumulator |
| acc_wdata | output | 12 | Accumulator write value |
| tx_req | output | 1 | One-cycle request to send `tx_char` |
| tx_char | output | 8 | Character to send |
| irq_pending | output | 1 | Gated terminal interrupt is pending |
| illegal | output | 1 | One-cycle pulse for an undefined I/O word |

## Verification
The enable sequence is tried with the enabling word followed by a skip-on-enable word, by idle gaps, by an illegal word and by a clear. These cases separate promotion on completion from promotion on time and from promotion on any word. The terminal flags are driven through every skip test with both flags clear, only the receive flag set, only the transmit flag set and both set, so that the shared skip can be told apart from the single-flag skips. Send-only and send-and-clear are each issued with the transmit flag already set. Same-cycle collisions of strobes with clearing instructions then check the priority rule. A long stretch of mixed words, characters and done pulses is compared on every clock against a behavioural model.

// File: rtl/conio_pkg.sv
package conio_pkg;
  typedef enum logic [3:0] {
    OP_NONE,
    OP_SKIP_IEN,
    OP_IEN_ON,
    OP_IEN_OFF,
    OP_SKIP_PEND,
    OP_SKIP_RX,
    OP_SET_RXIE,
    OP_READ_RX,
    OP_SET_TXF,
    OP_SKIP_TX,
    OP_CLR_TXF,
    OP_SEND,
    OP_SKIP_ANY,
    OP_SEND_CLR,
    OP_ILLEGAL
  } io_op_e;
endpackage

// File: rtl/conio_decode.sv
module conio_decode
  import conio_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int GRP_IOT  = 6,
  parameter int DEV_INTC = 0,
  parameter int DEV_KBD  = 3,
  parameter int DEV_PRT  = 4
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] instr,
  output io_op_e            op
);
  localparam int SUB_W = 3;
  localparam int DEV_W = 6;
  localparam logic [2:0]       GRP_C  = 3'(GRP_IOT);
  localparam logic [DEV_W-1:0] INTC_C = DEV_W'(DEV_INTC);
  localparam logic [DEV_W-1:0] KBD_C  = DEV_W'(DEV_KBD);
  localparam logic [DEV_W-1:0] PRT_C  = DEV_W'(DEV_PRT);

  logic [2:0]       grp;
  logic [DEV_W-1:0] dev;
  logic [SUB_W-1:0] sub;

  assign grp = instr[WORD_W-1 -: 3];
  assign dev = instr[SUB_W +: DEV_W];
  assign sub = instr[SUB_W-1:0];

  always_comb begin
    op = OP_NONE;
    if (valid && grp == GRP_C) begin
      op = OP_ILLEGAL;
      if (dev == INTC_C) begin
        case (sub)
          3'd0: op = OP_SKIP_IEN;
          3'd1: op = OP_IEN_ON;
          3'd2: op = OP_IEN_OFF;
          3'd3: op = OP_SKIP_PEND;
          default: op = OP_ILLEGAL;
        endcase
      end else if (dev == KBD_C) begin
        case (sub)
          3'd1: op = OP_SKIP_RX;
          3'd5: op = OP_SET_RXIE;
          3'd6: op = OP_READ_RX;
          default: op = OP_ILLEGAL;
        endcase
      end else if (dev == PRT_C) begin
        case (sub)
          3'd0: op = OP_SET_TXF;
          3'd1: op = OP_SKIP_TX;
          3'd2: op = OP_CLR_TXF;
          3'd4: op = OP_SEND;
          3'd5: op = OP_SKIP_ANY;
          3'd6: op = OP_SEND_CLR;
          default: op = OP_ILLEGAL;
        endcase
      end
    end
  end
endmodule

// File: rtl/conio_intr.sv
module conio_intr
  import conio_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   instr_done,
  input  io_op_e op,
  output logic   ien,
  output logic   ien_dly
);
  logic en_n, dly_n;

  always_comb begin
    en_n  = ien;
    dly_n = ien_dly;
    if (instr_done) begin
      if (ien_dly) en_n = 1'b1;
      dly_n = 1'b0;
      case (op)
        OP_IEN_ON:  dly_n = 1'b1;
        OP_IEN_OFF: begin
          en_n  = 1'b0;
          dly_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien     <= 1'b0;
      ien_dly <= 1'b0;
    end else begin
      ien     <= en_n;
      ien_dly <= dly_n;
    end
  end
endmodule

// File: rtl/conio_term.sv
module conio_term
  import conio_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  io_op_e            op,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              rx_strobe,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              tx_done,
  output logic              rx_flag,
  output logic              tx_flag,
  output logic [CHAR_W-1:0] rx_data,
  output logic [1:0]        rxie,
  output logic [CHAR_W-1:0] tx_char,
  output logic              tx_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
      rx_data <= '0;
      rxie    <= '0;
      tx_char <= '0;
      tx_req  <= 1'b0;
    end else begin
      tx_req <= 1'b0;
      case (op)
        OP_READ_RX:  rx_flag <= 1'b0;
        OP_SET_RXIE: rxie <= acc_in[1:0];
        OP_SET_TXF:  tx_flag <= 1'b1;
        OP_CLR_TXF:  tx_flag <= 1'b0;
        OP_SEND: begin
          tx_char <= acc_in[CHAR_W-1:0];
          tx_req  <= 1'b1;
        end
        OP_SEND_CLR: begin
          tx_char <= acc_in[CHAR_W-1:0];
          tx_req  <= 1'b1;
          tx_flag <= 1'b0;
        end
        default: ;
      endcase
      // line events override a same-cycle clear
      if (rx_strobe) begin
        rx_flag <= 1'b1;
        rx_data <= rx_char;
      end
      if (tx_done) tx_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/conio_unit.sv
module conio_unit
  import conio_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int CHAR_W   = 8,
  parameter int GRP_IOT  = 6,
  parameter int DEV_INTC = 0,
  parameter int DEV_KBD  = 3,
  parameter int DEV_PRT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              rx_strobe,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              tx_done,
  output logic              skip,
  output logic              acc_we,
  output logic [WORD_W-1:0] acc_wdata,
  output logic              tx_req,
  output logic [CHAR_W-1:0] tx_char,
  output logic              irq_pending,
  output logic              illegal
);
  localparam int PAD_W = WORD_W - CHAR_W;

  io_op_e            op;
  logic              ien, ien_dly;
  logic              rx_flag, tx_flag;
  logic [CHAR_W-1:0] rx_data;
  logic [1:0]        rxie;
  logic              skip_n;
  logic              done;

  conio_decode #(
    .WORD_W(WORD_W), .GRP_IOT(GRP_IOT),
    .DEV_INTC(DEV_INTC), .DEV_KBD(DEV_KBD), .DEV_PRT(DEV_PRT)
  ) u_dec (
    .valid(instr_valid), .instr(instr), .op(op)
  );

  assign done = instr_valid && (op != OP_ILLEGAL);

  conio_intr u_intr (
    .clk(clk), .rst(rst), .instr_done(done), .op(op),
    .ien(ien), .ien_dly(ien_dly)
  );

  conio_term #(.WORD_W(WORD_W), .CHAR_W(CHAR_W)) u_term (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in),
    .rx_strobe(rx_strobe), .rx_char(rx_char), .tx_done(tx_done),
    .rx_flag(rx_flag), .tx_flag(tx_flag), .rx_data(rx_data),
    .rxie(rxie), .tx_char(tx_char), .tx_req(tx_req)
  );

  assign irq_pending = (rxie[0] & rx_flag) | (rxie[1] & tx_flag);

  always_comb begin
    case (op)
      OP_SKIP_IEN:  skip_n = ien;
      OP_SKIP_PEND: skip_n = irq_pending;
      OP_SKIP_RX:   skip_n = rx_flag;
      OP_SKIP_TX:   skip_n = tx_flag;
      OP_SKIP_ANY:  skip_n = rx_flag | tx_flag;
      default:      skip_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      skip      <= 1'b0;
      acc_we    <= 1'b0;
      acc_wdata <= '0;
      illegal   <= 1'b0;
    end else begin
      skip      <= skip_n;
      acc_we    <= (op == OP_READ_RX);
      acc_wdata <= (op == OP_READ_RX) ? {{PAD_W{1'b0}}, rx_data} : '0;
      illegal   <= (op == OP_ILLEGAL);
    end
  end
endmodule

// File: rtl/conio_chk.sv
module conio_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              rx_strobe,
  input logic              tx_done,
  input logic              skip,
  input logic              acc_we,
  input logic [WORD_W-1:0] acc_wdata,
  input logic              tx_req,
  input logic              illegal,
  input logic              irq_pending
);
  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!skip && !acc_we && !tx_req));

  // R12
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!skip && !acc_we && !tx_req && !illegal));

  // R4
  pend_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid && !rx_strobe && !tx_done) |=> $stable(irq_pending));

  // R9
  tx_req_src_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |-> $past(instr_valid));

  // R6
  acc_we_src_chk: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> $past(instr_valid));

  // R12
  single_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({skip, acc_we, tx_req, illegal}) <= 1);
endmodule

bind conio_unit conio_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .rx_strobe(rx_strobe),
  .tx_done(tx_done), .skip(skip), .acc_we(acc_we), .acc_wdata(acc_wdata),
  .tx_req(tx_req), .illegal(illegal), .irq_pending(irq_pending)
);

// File: tb/conio_unit_test.sv
module conio_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [11:0] instr = '0;
  logic [11:0] acc_in = '0;
  logic        rx_strobe = 1'b0;
  logic [7:0]  rx_char = '0;
  logic        tx_done = 1'b0;
  logic        skip, acc_we, tx_req, irq_pending, illegal;
  logic [11:0] acc_wdata;
  logic [7:0]  tx_char;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int m_en = 0, m_dly = 0, m_kie = 0, m_rxf = 0, m_txf = 0, m_rxd = 0, m_txc = 0;
  int e_skip, e_we, e_wd, e_txr, e_ill, e_irq;

  always #5 clk = ~clk;

  conio_unit uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .acc_in(acc_in), .rx_strobe(rx_strobe), .rx_char(rx_char),
    .tx_done(tx_done), .skip(skip), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .tx_req(tx_req), .tx_char(tx_char), .irq_pending(irq_pending),
    .illegal(illegal)
  );

  task automatic compare(string tag);
    checks++;
    if (skip !== e_skip[0] || acc_we !== e_we[0] || acc_wdata !== 12'(e_wd) ||
        tx_req !== e_txr[0] || tx_char !== 8'(m_txc) || illegal !== e_ill[0] ||
        irq_pending !== e_irq[0]) begin
      errors++;
      $display("FAIL %s: got skip=%0b we=%0b wd=%o txr=%0b txc=%h ill=%0b irq=%0b exp skip=%0d we=%0d wd=%o txr=%0d txc=%h ill=%0d irq=%0d",
               tag, skip, acc_we, acc_wdata, tx_req, tx_char, illegal, irq_pending,
               e_skip, e_we, e_wd, e_txr, m_txc, e_ill, e_irq);
    end
  endtask

  task automatic step(string tag, bit v, int ins, int acc, bit rs, int rc, bit td);
    int g, d, s, pend;
    bit iot, known, done;
    instr_valid = v; instr = 12'(ins); acc_in = 12'(acc);
    rx_strobe = rs; rx_char = 8'(rc); tx_done = td;
    @(posedge clk);
    g = (ins >> 9) & 7; d = (ins >> 3) & 63; s = ins & 7;
    iot = v && g == 6;
    known = iot && ((d == 0 && s <= 3) ||
                    (d == 3 && (s == 1 || s == 5 || s == 6)) ||
                    (d == 4 && s != 3 && s != 7));
    pend = ((m_kie & 1) && m_rxf) || ((m_kie & 2) && m_txf);
    e_ill = iot && !known;
    done = v && !e_ill;
    e_skip = 0; e_we = 0; e_wd = 0; e_txr = 0;
    if (known) begin
      if (d == 0 && s == 0) e_skip = m_en;
      if (d == 0 && s == 3) e_skip = pend;
      if (d == 3 && s == 1) e_skip = m_rxf;
      if (d == 4 && s == 1) e_skip = m_txf;
      if (d == 4 && s == 5) e_skip = (m_rxf || m_txf) ? 1 : 0;
      if (d == 3 && s == 6) begin e_we = 1; e_wd = m_rxd; end
      if (d == 4 && (s == 4 || s == 6)) begin e_txr = 1; m_txc = acc & 255; end
    end
    if (done) begin
      if (m_dly != 0) m_en = 1;
      m_dly = 0;
      if (known && d == 0 && s == 1) m_dly = 1;
      if (known && d == 0 && s == 2) begin m_en = 0; m_dly = 0; end
    end
    if (known) begin
      if (d == 3 && s == 6) m_rxf = 0;
      if (d == 3 && s == 5) m_kie = acc & 3;
      if (d == 4 && s == 0) m_txf = 1;
      if (d == 4 && (s == 2 || s == 6)) m_txf = 0;
    end
    if (rs) begin m_rxf = 1; m_rxd = rc & 255; end
    if (td) m_txf = 1;
    e_irq = (((m_kie & 1) && m_rxf) || ((m_kie & 2) && m_txf)) ? 1 : 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic op(string tag, int ins, int acc = 0);
    step(tag, 1'b1, ins, acc, 1'b0, 0, 1'b0);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 0, 0, 1'b0, 0, 1'b0);
  endtask

  task automatic expect_bit(string tag, logic got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    e_skip = 0; e_we = 0; e_wd = 0; e_txr = 0; e_ill = 0; e_irq = 0;
    compare("R13");
    idle("R13");

    // R2 / R3 enable sequencing
    op("R2", 'o6000);
    expect_bit("R2 skon off", skip, 1'b0);
    op("R2", 'o6001);
    op("R3", 'o6000);
    expect_bit("R3 first after enable", skip, 1'b0);
    op("R3", 'o6000);
    expect_bit("R3 promoted", skip, 1'b1);
    op("R2", 'o6002);
    op("R2", 'o6000);
    expect_bit("R2 cleared", skip, 1'b0);
    op("R3", 'o6001);
    idle("R3"); idle("R3");
    op("R3", 'o6000);
    expect_bit("R3 idle no promote", skip, 1'b0);
    op("R3", 'o6000);
    op("R11", 'o6002);
    op("R11", 'o6001);
    op("R11", 'o6004);
    expect_bit("R11 illegal pulse", illegal, 1'b1);
    op("R11", 'o6000);
    expect_bit("R11 illegal no promote", skip, 1'b0);
    op("R11", 'o6000);
    expect_bit("R3 late promote", skip, 1'b1);
    op("R2", 'o6002);

    // R5 / R7 / R4 / R6 keyboard
    step("R5", 1'b0, 0, 0, 1'b1, 'hA5, 1'b0);
    op("R5", 'o6031);
    expect_bit("R5 rx skip", skip, 1'b1);
    op("R7", 'o6035, 'o7771);
    expect_bit("R4 pending rx", irq_pending, 1'b1);
    op("R4", 'o6003);
    expect_bit("R4 skip pend", skip, 1'b1);
    op("R6", 'o6036);
    expect_bit("R6 acc we", acc_we, 1'b1);
    op("R5", 'o6031);
    op("R4", 'o6003);

    // R8 / R10 / R9 printer
    op("R8", 'o6041);
    op("R10", 'o6045);
    op("R8", 'o6040);
    op("R8", 'o6041);
    op("R10", 'o6045);
    op("R8", 'o6042);
    op("R8", 'o6041);
    step("R10", 1'b0, 0, 0, 1'b1, 'h3C, 1'b0);
    op("R10", 'o6045);
    op("R6", 'o6036);
    op("R8", 'o6040);
    op("R9", 'o6044, 'o1234);
    op("R9", 'o6041);
    op("R9", 'o6046, 'h041);
    op("R9", 'o6041);
    step("R8", 1'b0, 0, 0, 1'b0, 0, 1'b1);
    op("R8", 'o6041);
    op("R4", 'o6035, 2);
    op("R4", 'o6003);
    op("R4", 'o6035, 0);

    // R11 / R1 other devices and groups
    op("R11", 'o6050);
    op("R11", 'o6047);
    op("R11", 'o6030);
    op("R1", 'o7000);
    op("R1", 'o5041);

    // R12 same-cycle priority
    step("R12", 1'b1, 'o6042, 0, 1'b0, 0, 1'b1);
    op("R12", 'o6041);
    step("R12", 1'b1, 'o6036, 0, 1'b1, 'h5A, 1'b0);
    op("R12", 'o6031);
    op("R12", 'o6036);

    // R12 mixed traffic compared every clock
    for (int i = 0; i < 400; i++) begin
      int pick;
      int codes[16] = '{'o6000, 'o6001, 'o6002, 'o6003, 'o6031, 'o6035, 'o6036,
                        'o6040, 'o6041, 'o6042, 'o6044, 'o6045, 'o6046,
                        'o6050, 'o7000, 'o6047};
      pick = int'($urandom_range(15, 0));
      step("R12", ($urandom_range(3, 0) != 0), codes[pick],
           int'($urandom_range(4095, 0)), ($urandom_range(3, 0) == 0),
           int'($urandom_range(255, 0)), ($urandom_range(7, 0) == 0));
    end
    idle("R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule